// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

A purely combinational 8-bit datapath slice for a small processor core. It takes one operand byte and an operation code and returns the transformed byte along with a write-back strobe and the four condition flags: zero, subtract, half-carry and carry. It handles circular rotates, rotates through carry, left shifts, arithmetic and logical right shifts, nibble exchange, single-bit test, single-bit clear and single-bit set.

The surrounding core fetches the operand from a register or from memory. It presents the current flags and, for the bit operations, a 3-bit bit index. It then commits `res_o` and the flag outputs in the same cycle. When `wr_en_o` is low, the operand must not be written back. Two groups of rotates exist. The accumulator group always reports zero as clear. The general group derives the zero flag from the result.

Top module: `bitrot_unit`

## Requirements
- R1: Circular rotates (codes 0 and 4 rotate left, codes 1 and 5 rotate right) move the bit that leaves one end into the other end and into the carry flag.
- R2: Rotates through carry (codes 2 and 6 left, codes 3 and 7 right) shift the incoming carry into the vacated end (bit 0 for left, bit 7 for right) and move the bit that leaves into the carry flag.
- R3: For the accumulator rotate codes 0 to 3, the zero, subtract and half-carry outputs are all 0, whatever the result.
- R4: For codes 4 to 11, the zero output is 1 exactly when the result is 0x00, and the subtract and half-carry outputs are 0.
- R5: Code 8 shifts left with bit 0 filled with 0, and bit 7 of the operand goes to the carry flag.
- R6: Code 9 shifts right and keeps bit 7. Code 10 shifts right and fills bit 7 with 0. Both place operand bit 0 in the carry flag.
- R7: Code 11 exchanges the upper and lower nibbles and clears the carry flag.
- R8: Code 12 tests bit `bit_sel_i`. It sets zero to the inverse of that bit, clears subtract, sets half-carry, keeps the incoming carry, drives the operand unchanged on `res_o`, and holds `wr_en_o` low.
- R9: Code 13 clears and code 14 sets only bit `bit_sel_i`. All four flag outputs equal the flag inputs.
- R10: `wr_en_o` is high for every code from 0 to 14 except 12. Reserved code 15 passes the operand and all flags through unchanged with `wr_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 to 15) |
| opnd_i | input | 8 | Operand byte |
| bit_sel_i | input | 3 | Bit index for codes 12 to 14 |
| z_i | input | 1 | Incoming zero flag |
| n_i | input | 1 | Incoming subtract flag |
| h_i | input | 1 | Incoming half-carry flag |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Write-back strobe |
| z_o | output | 1 | Updated zero flag |
| n_o | output | 1 | Updated subtract flag |
| h_o | output | 1 | Updated half-carry flag |
| c_o | output | 1 | Updated carry flag |

## Verification
The assertions check the flag rules on every evaluation:
- the forced zero/subtract/half-carry of the accumulator group;
- the result-derived zero of the general group;
- the fixed flags and suppressed write-back of the bit test;
- the untouched flags and single-bit change of clear and set;
- the write-back strobe for each code.

The actual bit movement is left to the bench scenarios, which compare against an independent reference. This covers rotate direction, where the incoming carry lands, sign fill versus zero fill, and the nibble exchange. It includes the boundary operands 0x00, 0x01, 0x80 and 0xFF, with both carry values.

// File: rtl/bitrot_unit.sv
module bitrot_unit #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  input  logic              z_i,
  input  logic              n_i,
  input  logic              h_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              z_o,
  output logic              n_o,
  output logic              h_o,
  output logic              c_o
);

  localparam logic [3:0] OP_ACC_RLC = 4'd0, OP_ACC_RRC = 4'd1,
                         OP_ACC_RL  = 4'd2, OP_ACC_RR  = 4'd3,
                         OP_RLC     = 4'd4, OP_RRC     = 4'd5,
                         OP_RL      = 4'd6, OP_RR      = 4'd7,
                         OP_SHL     = 4'd8, OP_SAR     = 4'd9,
                         OP_SHR     = 4'd10, OP_SWAP   = 4'd11,
                         OP_TEST    = 4'd12, OP_CLR    = 4'd13,
                         OP_SET     = 4'd14;

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sel_mask;
  logic              acc_grp, gen_grp;

  assign sel_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel_i;
  assign acc_grp  = (op_i <= OP_ACC_RR);
  assign gen_grp  = (op_i >= OP_RLC) && (op_i <= OP_SWAP);

  always_comb begin
    res_o   = opnd_i;
    c_o     = c_i;
    wr_en_o = 1'b1;
    case (op_i)
      OP_ACC_RLC, OP_RLC: begin
        res_o = {opnd_i[MSB-1:0], opnd_i[MSB]};
        c_o   = opnd_i[MSB];
      end
      OP_ACC_RRC, OP_RRC: begin
        res_o = {opnd_i[0], opnd_i[MSB:1]};
        c_o   = opnd_i[0];
      end
      OP_ACC_RL, OP_RL: begin
        res_o = {opnd_i[MSB-1:0], c_i};
        c_o   = opnd_i[MSB];
      end
      OP_ACC_RR, OP_RR: begin
        res_o = {c_i, opnd_i[MSB:1]};
        c_o   = opnd_i[0];
      end
      OP_SHL: begin
        res_o = {opnd_i[MSB-1:0], 1'b0};
        c_o   = opnd_i[MSB];
      end
      OP_SAR: begin
        res_o = {opnd_i[MSB], opnd_i[MSB:1]};
        c_o   = opnd_i[0];
      end
      OP_SHR: begin
        res_o = {1'b0, opnd_i[MSB:1]};
        c_o   = opnd_i[0];
      end
      OP_SWAP: begin
        res_o = {opnd_i[HALF-1:0], opnd_i[DATA_W-1:HALF]};
        c_o   = 1'b0;
      end
      OP_TEST: wr_en_o = 1'b0;
      OP_CLR:  res_o = opnd_i & ~sel_mask;
      OP_SET:  res_o = opnd_i | sel_mask;
      default: wr_en_o = 1'b0;
    endcase
  end

  always_comb begin
    z_o = z_i;
    n_o = n_i;
    h_o = h_i;
    if (acc_grp) begin
      z_o = 1'b0;
      n_o = 1'b0;
      h_o = 1'b0;
    end else if (gen_grp) begin
      z_o = (res_o == '0);
      n_o = 1'b0;
      h_o = 1'b0;
    end else if (op_i == OP_TEST) begin
      z_o = ~|(opnd_i & sel_mask);
      n_o = 1'b0;
      h_o = 1'b1;
    end
  end

endmodule

// File: rtl/bitrot_unit_chk.sv
module bitrot_unit_chk #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [IDX_W-1:0]  bit_sel_i,
  input logic              z_i,
  input logic              n_i,
  input logic              h_i,
  input logic              c_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic              z_o,
  input logic              n_o,
  input logic              h_o,
  input logic              c_o
);
  always_comb begin
    if (op_i <= 4'd3)
      AST_ACC_FLAGS_CLEAR: assert (!z_o && !n_o && !h_o); // R3
    if (op_i >= 4'd4 && op_i <= 4'd11)
      AST_GEN_ZERO_FLAG: assert (z_o == (res_o == '0) && !n_o && !h_o); // R4
    if (op_i == 4'd12)
      AST_TEST_FLAGS: assert (z_o == !opnd_i[bit_sel_i] && !n_o && h_o && c_o == c_i && !wr_en_o && res_o == opnd_i); // R8
    if (op_i == 4'd13 || op_i == 4'd14)
      AST_BITMOD_KEEPS_FLAGS: assert (z_o == z_i && n_o == n_i && h_o == h_i && c_o == c_i && $countones(res_o ^ opnd_i) <= 1); // R9
    if (op_i == 4'd11)
      AST_SWAP_CLEARS_C: assert (!c_o); // R7
    AST_WREN_BY_CODE: assert (wr_en_o == (op_i != 4'd12 && op_i != 4'd15)); // R10
  end
endmodule

bind bitrot_unit bitrot_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_bitrot_unit.sv
module test_bitrot_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] op;
  logic [7:0] opnd;
  logic [2:0] bsel;
  logic zi, ni, hi, ci;
  logic [7:0] res;
  logic we, zo, no, ho, co;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bitrot_unit i_bitrot_unit (
    .op_i(op), .opnd_i(opnd), .bit_sel_i(bsel),
    .z_i(zi), .n_i(ni), .h_i(hi), .c_i(ci),
    .res_o(res), .wr_en_o(we), .z_o(zo), .n_o(no), .h_o(ho), .c_o(co)
  );

  // {res, we, z, n, h, c}
  function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] v,
                                        input logic [2:0] b, input logic [3:0] f);
    logic [7:0] r;
    logic w, z, n, h, c;
    r = v; w = 1'b1; z = f[3]; n = f[2]; h = f[1]; c = f[0];
    case (o)
      0, 4:  begin r = (v << 1) | (v >> 7); c = v[7]; end
      1, 5:  begin r = (v >> 1) | (v << 7); c = v[0]; end
      2, 6:  begin r = (v << 1) | {7'd0, f[0]}; c = v[7]; end
      3, 7:  begin r = (v >> 1) | {f[0], 7'd0}; c = v[0]; end
      8:     begin r = v << 1; c = v[7]; end
      9:     begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
      10:    begin r = v >> 1; c = v[0]; end
      11:    begin r = (v << 4) | (v >> 4); c = 1'b0; end
      12:    begin w = 1'b0; z = ((v >> b) & 8'd1) == 8'd0; n = 1'b0; h = 1'b1; end
      13:    r = v & ~(8'd1 << b);
      14:    r = v | (8'd1 << b);
      default: w = 1'b0;
    endcase
    if (o <= 3) begin z = 1'b0; n = 1'b0; h = 1'b0; end
    else if (o <= 11) begin z = (r == 8'd0); n = 1'b0; h = 1'b0; end
    return {r, w, z, n, h, c};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      0, 1, 4, 5: return "R1/R3/R4";
      2, 3, 6, 7: return "R2/R3/R4";
      8:          return "R5";
      9, 10:      return "R6";
      11:         return "R7";
      12:         return "R8";
      13, 14:     return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] v,
                       input logic [2:0] b, input logic [3:0] f);
    logic [12:0] exp_v, got;
    @(negedge clk);
    op = o; opnd = v; bsel = b; {zi, ni, hi, ci} = f;
    #2;
    exp_v = model(o, v, b, f);
    got = {res, we, zo, no, ho, co};
    n_cmp++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d opnd=%h sel=%0d f=%b: got res=%h we,z,n,h,c=%b expected res=%h we,z,n,h,c=%b",
               tag(o), o, v, b, f, got[12:5], got[4:0], exp_v[12:5], exp_v[4:0]);
    end
  endtask

  initial begin
    op = 4'd15; opnd = 8'h00; bsel = 3'd0; {zi, ni, hi, ci} = 4'b0000;
    // idle state: reserved code passes through, no write-back (R10)
    apply(4'd15, 8'h00, 3'd0, 4'b0000);
    apply(4'd15, 8'hA5, 3'd3, 4'b1111);   // R10
    // boundary operands across every code and both carries (R1..R9)
    for (int o = 0; o < 16; o++)
      for (int k = 0; k < 4; k++)
        for (int cc = 0; cc < 2; cc++) begin
          logic [7:0] v;
          v = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : 8'hFF;
          apply(o[3:0], v, 3'(k * 3), {1'b1, 1'b1, 1'b0, cc[0]});
        end
    apply(4'd0, 8'h00, 3'd0, 4'b1110);    // R3 zero result, Z forced low
    apply(4'd4, 8'h00, 3'd0, 4'b0000);    // R4 zero result, Z high
    apply(4'd2, 8'h80, 3'd0, 4'b0000);    // R2/R3 result 0, carry out
    apply(4'd6, 8'h80, 3'd0, 4'b0000);    // R2/R4
    apply(4'd9, 8'h81, 3'd0, 4'b0000);    // R6 sign kept
    apply(4'd10, 8'h81, 3'd0, 4'b0000);   // R6 zero fill
    apply(4'd11, 8'h3C, 3'd0, 4'b0001);   // R7
    for (int b = 0; b < 8; b++) begin
      apply(4'd12, 8'h5A, b[2:0], 4'b0101);   // R8
      apply(4'd13, 8'hFF, b[2:0], 4'b1010);   // R9
      apply(4'd14, 8'h00, b[2:0], 4'b0101);   // R9
    end
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom), 8'($urandom), 3'($urandom), 4'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule